// File: doc/BRIEF.md
# Capacitive Divider Sensing Conversion Sequencer

This block controls one capacitive-divider measurement on a 10-bit successive-approximation converter. Software pulses a start request. The block then runs up to two timed analog phases before it converts. The first phase drives the external electrode toward the supply or toward ground. The second phase lets the external and internal capacitors share charge. Each phase lasts a programmable number of instruction cycles, and a count of zero removes that phase. When both counts are zero, the request goes straight to a conventional conversion.

During conversion the block disconnects the hold capacitor from the input. It then runs a bit-serial binary search, clocked by a divided conversion clock. It presents the trial code to the capacitor DAC and reads the comparator decision back as a single bit. One clock after the last decision it stores the result in a 16-bit register, right- or left-justified. In the same clock it raises the interrupt flag and drops the busy/start indication. Running a second sample with the opposite drive polarity gives differential operation. The analog array, the comparator and the pads are outside this block.

Top module: `cvd_sar_seq`

## Requirements
- R1: A `go_set` pulse while idle starts a sequence. `go` stays 1 from the next clock until completion. A `go_set` pulse while `go` is 1 has no effect on the phase lengths or on the result.
- R2: When `pre_cnt` is nonzero, `pre_drive` is 1 for exactly `pre_cnt`×INST_CLKS clocks. During those clocks `pre_high` equals `pre_pol` (1 = drive toward supply, 0 = toward ground).
- R3: When `acq_cnt` is nonzero, `share` is 1 for exactly `acq_cnt`×INST_CLKS clocks, following the precharge phase if one is present.
- R4: A zero count removes its phase. With both counts zero, `hold_disc` is 1 in the clock right after the start request.
- R5: `hold_disc` is 1 for exactly 11×(`conv_div`+1)+1 clocks per completed sequence: 11 conversion periods plus the completion clock. At most one of `pre_drive`, `share` and `hold_disc` is 1 at a time.
- R6: Conversion periods 1 to 10 resolve bits 9 down to 0. In each of these periods `sar_code` shows the kept bits plus the trial bit. `cmp_in` is sampled on the last clock of the period, and `cmp_in`=1 keeps the trial bit. With `cmp_in` = (input ≥ `sar_code`) the result equals the input.
- R7: One clock after the last decision, `result` is loaded, `int_flag` becomes 1 and `go` becomes 0, all in the same clock.
- R8: `cap_conn` equals `cap_en` during precharge and sharing. It is 0 at all other times, and always 0 while `hold_disc` is 1.
- R9: `go_clr` while busy returns the block to idle on the next clock (`go`=0, all strobes 0). `result` and `int_flag` keep their values.
- R10: The format is sampled at load. `left_fmt`=0 stores {6'b0, code}. `left_fmt`=1 stores {code, 6'b0}.
- R11: `int_clr` sets `int_flag` to 0 on the next clock, unless a completion happens in that same clock.
- R12: After reset, `go`, all strobes, `sar_code`, `result` and `int_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go_set | input | 1 | Start request pulse |
| go_clr | input | 1 | Abort request pulse |
| pre_cnt | input | 8 | Precharge length in instruction cycles, 0 = skip |
| acq_cnt | input | 8 | Charge-sharing length in instruction cycles, 0 = skip |
| conv_div | input | 4 | Conversion period = conv_div+1 system clocks |
| pre_pol | input | 1 | Precharge drive polarity, 1 = toward supply |
| left_fmt | input | 1 | Result justification, 1 = left |
| cap_en | input | 1 | Extra hold capacitance selected |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above trial code |
| int_clr | input | 1 | Clear the interrupt flag |
| go | output | 1 | Start bit / busy |
| pre_drive | output | 1 | Precharge phase strobe |
| pre_high | output | 1 | Precharge drive direction |
| share | output | 1 | Charge-sharing phase strobe |
| hold_disc | output | 1 | Hold capacitor disconnected (conversion) |
| cap_conn | output | 1 | Extra capacitance connected |
| sar_code | output | 10 | Trial code to the capacitor DAC |
| result | output | 16 | Justified conversion result |
| int_flag | output | 1 | Completion interrupt flag |

## Verification
The assertions assume that the phase counts, divider, polarity, format and capacitance select are held steady while a sequence runs. They also assume that `cmp_in` is a settled function of the current `sar_code`. The bench changes these settings only at a falling edge while the block is idle. It derives `cmp_in` combinationally from a fixed input value compared against `sar_code`. Abort and repeated-start pulses are single clocks, driven away from the sampling edge.

// File: rtl/cvd_pkg.sv
package cvd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACQ,
    ST_CONV,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/cvd_phase_timer.sv
module cvd_phase_timer #(
  parameter int PH_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [PH_W-1:0] load_val,
  input  logic            run,
  output logic            zero
);
  logic [PH_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2/R3: a running timer never wraps from zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && run && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/cvd_conv_clk.sv
module cvd_conv_clk #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             last
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (restart)     cnt <= div;
    else if (cnt == '0)   cnt <= div;
    else                  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/cvd_sar_core.sv
module cvd_sar_core #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           step,
  input  logic           cmp_in,
  output logic [RES-1:0] code,
  output logic [RES-1:0] raw,
  output logic           fin
);
  localparam int PER_W = $clog2(RES + 2);

  logic [PER_W-1:0] per;
  logic [RES-1:0]   sar;
  logic [RES-1:0]   trial;

  // period p (1..RES) tries bit RES-p
  for (genvar k = 0; k < RES; k++) begin : g_trial
    assign trial[k] = (per == PER_W'(RES - k));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      per <= '0;
      sar <= '0;
    end else if (step) begin
      sar <= (sar & ~trial) | (cmp_in ? trial : '0);
      per <= per + 1'b1;
    end
  end

  assign code = sar | trial;
  assign raw  = sar;
  assign fin  = step && (per == PER_W'(RES));

  // R6: at most one trial bit is offered at a time
  p_one_trial_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trial));
endmodule

// File: rtl/cvd_sar_seq.sv
module cvd_sar_seq #(
  parameter int RES       = 10,
  parameter int CNT_W     = 8,
  parameter int DIV_W     = 4,
  parameter int INST_CLKS = 4,
  parameter int OUT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_set,
  input  logic              go_clr,
  input  logic [CNT_W-1:0]  pre_cnt,
  input  logic [CNT_W-1:0]  acq_cnt,
  input  logic [DIV_W-1:0]  conv_div,
  input  logic              pre_pol,
  input  logic              left_fmt,
  input  logic              cap_en,
  input  logic              cmp_in,
  input  logic              int_clr,
  output logic              go,
  output logic              pre_drive,
  output logic              pre_high,
  output logic              share,
  output logic              hold_disc,
  output logic              cap_conn,
  output logic [RES-1:0]    sar_code,
  output logic [OUT_W-1:0]  result,
  output logic              int_flag
);
  import cvd_pkg::*;

  localparam int PH_W = CNT_W + $clog2(INST_CLKS + 1) + 1;
  localparam int PAD  = OUT_W - RES;

  seq_state_t st, nxt;
  logic            tmr_load, tmr_zero, tmr_run;
  logic [PH_W-1:0] tmr_val, pre_len, acq_len;
  logic            conv_start, div_last, step, sar_fin, done_load;
  logic [RES-1:0]  code, raw;

  assign pre_len = PH_W'(pre_cnt) * PH_W'(INST_CLKS) - 1'b1;
  assign acq_len = PH_W'(acq_cnt) * PH_W'(INST_CLKS) - 1'b1;

  always_comb begin
    nxt        = st;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    conv_start = 1'b0;
    case (st)
      ST_IDLE: if (go_set && !go_clr) begin
        if (pre_cnt != '0) begin
          nxt = ST_PRE; tmr_load = 1'b1; tmr_val = pre_len;
        end else if (acq_cnt != '0) begin
          nxt = ST_ACQ; tmr_load = 1'b1; tmr_val = acq_len;
        end else begin
          nxt = ST_CONV; conv_start = 1'b1;
        end
      end
      ST_PRE: if (go_clr) nxt = ST_IDLE;
        else if (tmr_zero) begin
          if (acq_cnt != '0) begin
            nxt = ST_ACQ; tmr_load = 1'b1; tmr_val = acq_len;
          end else begin
            nxt = ST_CONV; conv_start = 1'b1;
          end
        end
      ST_ACQ: if (go_clr) nxt = ST_IDLE;
        else if (tmr_zero) begin
          nxt = ST_CONV; conv_start = 1'b1;
        end
      ST_CONV: if (go_clr) nxt = ST_IDLE;
        else if (sar_fin) nxt = ST_DONE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign tmr_run   = (st == ST_PRE) || (st == ST_ACQ);
  assign step      = (st == ST_CONV) && div_last;
  assign done_load = (st == ST_DONE) && !go_clr;

  cvd_phase_timer #(.PH_W(PH_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .zero(tmr_zero));

  cvd_conv_clk #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .restart(conv_start), .div(conv_div),
    .last(div_last));

  cvd_sar_core #(.RES(RES)) u_sar (
    .clk(clk), .rst(rst), .clear(conv_start), .step(step),
    .cmp_in(cmp_in), .code(code), .raw(raw), .fin(sar_fin));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      result   <= '0;
      int_flag <= 1'b0;
    end else begin
      st <= nxt;
      if (done_load) begin
        result   <= left_fmt ? {raw, {PAD{1'b0}}} : {{PAD{1'b0}}, raw};
        int_flag <= 1'b1;
      end else if (int_clr) begin
        int_flag <= 1'b0;
      end
    end
  end

  assign go        = (st != ST_IDLE);
  assign pre_drive = (st == ST_PRE);
  assign pre_high  = (st == ST_PRE) && pre_pol;
  assign share     = (st == ST_ACQ);
  assign hold_disc = (st == ST_CONV) || (st == ST_DONE);
  assign cap_conn  = cap_en && tmr_run;
  assign sar_code  = (st == ST_CONV || st == ST_DONE) ? code : '0;

  p_phase_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pre_drive, share, hold_disc}));
  p_cap_off_conv_r8: assert property (@(posedge clk) disable iff (rst)
    hold_disc |-> !cap_conn);
  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (go && go_clr) |=> (!go && $stable(result) && $stable(int_flag)));
  p_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(int_flag) |-> (!go && $past(hold_disc)));
  p_direct_r4: assert property (@(posedge clk) disable iff (rst)
    (!go && go_set && !go_clr && pre_cnt == '0 && acq_cnt == '0) |=> hold_disc);
endmodule

// File: tb/cvd_sar_seq_test.sv
module cvd_sar_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go_set = 0, go_clr = 0, pre_pol = 0, left_fmt = 0, cap_en = 0, int_clr = 0;
  logic [7:0] pre_cnt = 0, acq_cnt = 0;
  logic [3:0] conv_div = 0;
  logic [9:0] vin = 0;
  logic go, pre_drive, pre_high, share, hold_disc, cap_conn, int_flag, cmp_in;
  logic [9:0]  sar_code;
  logic [15:0] result;
  int checks = 0, errors = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;
  assign cmp_in = (vin >= sar_code);

  cvd_sar_seq uut (
    .clk(clk), .rst(rst), .go_set(go_set), .go_clr(go_clr),
    .pre_cnt(pre_cnt), .acq_cnt(acq_cnt), .conv_div(conv_div),
    .pre_pol(pre_pol), .left_fmt(left_fmt), .cap_en(cap_en),
    .cmp_in(cmp_in), .int_clr(int_clr), .go(go), .pre_drive(pre_drive),
    .pre_high(pre_high), .share(share), .hold_disc(hold_disc),
    .cap_conn(cap_conn), .sar_code(sar_code), .result(result),
    .int_flag(int_flag));

  // {pre, acq, div, pol, fmt, cap, value}
  localparam logic [32:0] VEC [0:7] = '{
    {8'd3,   8'd5,   4'd1,  1'b1, 1'b0, 1'b1, 10'h2A5},
    {8'd0,   8'd0,   4'd0,  1'b0, 1'b0, 1'b1, 10'h000},
    {8'd0,   8'd7,   4'd3,  1'b0, 1'b1, 1'b1, 10'h3FF},
    {8'd4,   8'd0,   4'd2,  1'b0, 1'b1, 1'b0, 10'h155},
    {8'd1,   8'd1,   4'd15, 1'b1, 1'b0, 1'b1, 10'h200},
    {8'd255, 8'd1,   4'd0,  1'b0, 1'b0, 1'b1, 10'h1FF},
    {8'd2,   8'd255, 4'd1,  1'b1, 1'b1, 1'b1, 10'h001},
    {8'd0,   8'd0,   4'd5,  1'b1, 1'b1, 1'b0, 10'h3FE}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [32:0] v, input int poke);
    int npre = 0, nacq = 0, nhold = 0, bpol = 0, bcap = 0, bgo = 0, i = 0;
    bit first_pre, first_hold;
    logic [15:0] expr;
    pre_cnt = v[32:25]; acq_cnt = v[24:17]; conv_div = v[16:13];
    pre_pol = v[12]; left_fmt = v[11]; cap_en = v[10]; vin = v[9:0];
    go_set = 1;
    @(negedge clk);
    go_set = 0;
    first_pre = pre_drive; first_hold = hold_disc;
    while (!int_flag && i < 20000) begin
      if (pre_drive) npre++;
      if (pre_drive && pre_high != pre_pol) bpol++;
      if (share) nacq++;
      if (hold_disc) nhold++;
      if (cap_conn != (cap_en && (pre_drive || share))) bcap++;
      if (!go) bgo++;
      go_set = (i == poke);
      @(negedge clk);
      i++;
    end
    go_set = 0;
    // R4: skipped phases
    if (pre_cnt == 0) chk(!first_pre, "R4 pre skipped", first_pre, 0);
    if (pre_cnt == 0 && acq_cnt == 0) chk(first_hold, "R4 direct conversion", first_hold, 1);
    chk(npre == pre_cnt * 4, "R2 precharge length", npre, pre_cnt * 4);
    chk(bpol == 0, "R2 polarity", bpol, 0);
    chk(nacq == acq_cnt * 4, "R3 sharing length", nacq, acq_cnt * 4);
    chk(nhold == 11 * (conv_div + 1) + 1, "R5 conversion length", nhold, 11 * (conv_div + 1) + 1);
    chk(bcap == 0, "R8 extra capacitance", bcap, 0);
    chk(bgo == 0, "R1 go held while busy", bgo, 0);
    chk(int_flag && !go, "R7 flag with go cleared", {int_flag, go}, 2);
    expr = left_fmt ? {vin, 6'b0} : {6'b0, vin};
    chk(result == expr, "R6 R10 result", result, expr);
    int_clr = 1;
    @(negedge clk);
    int_clr = 0;
    chk(!int_flag, "R11 flag cleared", int_flag, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    rst = 0;
    // R12: reset state
    chk({go, pre_drive, share, hold_disc, cap_conn, int_flag} == 0, "R12 strobes", {go, pre_drive, share, hold_disc, cap_conn, int_flag}, 0);
    chk(result == 0 && sar_code == 0, "R12 result", result, 0);

    for (int n = 0; n < 8; n++) run_seq(VEC[n], -1);

    // R1: start request while busy is ignored
    run_seq({8'd2, 8'd0, 4'd0, 1'b0, 1'b0, 1'b1, 10'h0C3}, 3);
    run_seq({8'd0, 8'd0, 4'd1, 1'b0, 1'b0, 1'b0, 10'h2F0}, 10);

    // R9: abort during precharge
    keep = result;
    pre_cnt = 20; acq_cnt = 3; conv_div = 0; vin = 10'h111;
    go_set = 1; @(negedge clk); go_set = 0;
    repeat (10) @(negedge clk);
    go_clr = 1; @(negedge clk); go_clr = 0;
    chk(!go && !pre_drive && !cap_conn, "R9 abort precharge idle", go, 0);
    chk(result == keep && !int_flag, "R9 abort keeps result", result, keep);

    // R9: abort during conversion
    pre_cnt = 0; acq_cnt = 0; conv_div = 3; vin = 10'h0AA;
    go_set = 1; @(negedge clk); go_set = 0;
    repeat (20) @(negedge clk);
    chk(hold_disc, "R5 converting before abort", hold_disc, 1);
    go_clr = 1; @(negedge clk); go_clr = 0;
    chk(!go && !hold_disc && sar_code == 0, "R9 abort conversion idle", go, 0);
    chk(result == keep && !int_flag, "R9 abort conversion keeps result", result, keep);
    repeat (60) @(negedge clk);
    chk(!int_flag && result == keep, "R9 no late completion", int_flag, 0);

    // R2: opposite polarity second sample
    run_seq({8'd6, 8'd2, 4'd2, 1'b0, 1'b0, 1'b1, 10'h123}, -1);
    run_seq({8'd6, 8'd2, 4'd2, 1'b1, 1'b0, 1'b1, 10'h123}, -1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule